// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block walks chains of DMA descriptors kept in word-addressed memory and hands the transfer parameters of each one (buffer address, length, configuration) to a separate data engine. Descriptor words are read one at a time through a request/response port that uses valid and ready handshakes. Software sets a layout mode, the pointer to the first descriptor and a set of shadow values, then pulses `start`. The sequencer fetches a descriptor, presents it with `xfer_valid` held high, and waits. When the engine pulses `eng_done`, the sequencer moves on to the next descriptor or stops.

Four layouts are supported. In the ring layout each descriptor is a two-word pair (link, buffer address). In the list layout each descriptor holds four words (link, address, length, configuration). In the array layout each descriptor is a single address word, and descriptors lie at consecutive memory words. In the full layout the descriptor holds four words with the configuration first, so every field of every transfer can be reprogrammed. Layouts without a length or configuration field take those values from shadow inputs.

While a transfer runs, the engine pulses `eng_beat` once per word moved. The sequencer then raises `irq_frac` at the half point or at each quarter point of the buffer, as the descriptor asks. It can also raise a buffer-end interrupt and a chain-finished interrupt.

Top module: `dsc_fetch_seq`

## Requirements
- R1: After reset `busy`, `xfer_valid`, `mem_req_valid`, `irq_frac`, `irq_buf` and `irq_done` are all low.
- R2: Ring mode (`cfg_mode`=0): each descriptor is two words, the link at the base and the buffer address at base+1. Length and configuration come from `shadow_len`/`shadow_cfg`, sampled when each descriptor fetch begins. The next descriptor is the one the link names, so a two-entry ring alternates its buffers.
- R3: List mode (`cfg_mode`=1): each descriptor is four words, in the order link, address, length, configuration, at base+0 to base+3.
- R4: Array mode (`cfg_mode`=2): each descriptor is one address word. The next descriptor sits at the following word. Length and configuration come from the shadow inputs. The walk ends after `arr_count` descriptors.
- R5: Full mode (`cfg_mode`=3): each descriptor is four words, in the order configuration, link, address, length.
- R6: Configuration bit 0 marks the last descriptor. When `eng_done` arrives for it, the link is not followed: `irq_done` pulses for one cycle and `busy` falls in that same cycle.
- R7: No descriptor read is requested while `xfer_valid` is high. The next fetch starts only after `eng_done`, and the presented fields stay stable until then.
- R8: At most one descriptor read is outstanding. A request stays valid with a stable address until it is accepted, and no new request is made until its response returns.
- R9: Configuration bits [3:2]=01 select a half-buffer interrupt: `irq_frac` pulses once, in the cycle after beat number len/2 (integer division).
- R10: Configuration bits [3:2]=10 select quarter interrupts: `irq_frac` pulses in the cycle after beats q, 2q and 3q, where q=len/4. Values 00 and 11 give no fractional interrupt.
- R11: Configuration bit 1 enables the buffer-end interrupt: `irq_buf` pulses for one cycle after the `eng_done` of that descriptor, and stays low when the bit is clear.
- R12: A beat that reaches a fractional mark in the same cycle as `eng_done` still produces `irq_frac`, in the same cycle as `irq_buf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 2 | Descriptor layout: 0 ring, 1 list, 2 array, 3 full |
| start | input | 1 | Pulse that begins a walk at `first_ptr` when idle |
| first_ptr | input | AW | Word address of the first descriptor |
| shadow_len | input | LW | Length used when the layout carries no length |
| shadow_cfg | input | CW | Configuration used when the layout carries none |
| arr_count | input | NW | Number of descriptors in array mode |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_addr | output | AW | Word address of the read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | DW | Read data |
| xfer_valid | output | 1 | Transfer parameters are presented |
| xfer_addr | output | AW | Buffer start address |
| xfer_len | output | LW | Buffer length in words |
| xfer_cfg | output | CW | Configuration of the transfer |
| eng_beat | input | 1 | One word moved by the data engine |
| eng_done | input | 1 | Data engine finished the current transfer |
| irq_frac | output | 1 | Fractional-point interrupt pulse |
| irq_buf | output | 1 | Buffer-end interrupt pulse |
| irq_done | output | 1 | Chain-finished interrupt pulse |
| busy | output | 1 | A walk is in progress |

## Verification
The fractional-point counter and the end-of-buffer logic can act in the same clock cycle, when the engine reports a beat that lands on a quarter mark together with its done pulse. The bench provokes this on a quarter-interrupt descriptor of length 8. It sends the first beat alone, then drives the second beat and `eng_done` together. In the following cycle it requires `irq_frac`, `irq_buf` and `irq_done` all high, so neither event may mask the other. Ready stalls on the read port let the one-outstanding rule and the no-fetch-during-transfer rule be watched under backpressure.

// File: rtl/dsc_pkg.sv
// Package: shared types and layout tables for the descriptor sequencer.
// Assumes descriptor words are word addressed and at most four per descriptor.
package dsc_pkg;

    typedef enum logic [1:0] {
        MODE_RING  = 2'd0,
        MODE_LIST  = 2'd1,
        MODE_ARRAY = 2'd2,
        MODE_FULL  = 2'd3
    } dsc_mode_e;

    typedef enum logic [1:0] {
        ROLE_LINK = 2'd0,
        ROLE_ADDR = 2'd1,
        ROLE_LEN  = 2'd2,
        ROLE_CFG  = 2'd3
    } dsc_role_e;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2,
        WK_XFER  = 2'd3
    } walk_st_e;

    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_REQ  = 2'd1,
        RP_WAIT = 2'd2
    } rdp_st_e;

    // Configuration bit positions
    localparam int CFG_LAST_BIT = 0;
    localparam int CFG_END_BIT  = 1;
    localparam int CFG_FRAC_LO  = 2;

    localparam logic [1:0] FRAC_HALF    = 2'b01;
    localparam logic [1:0] FRAC_QUARTER = 2'b10;

    // Index of the final word of a descriptor in the given layout
    function automatic logic [1:0] last_word_idx(dsc_mode_e m);
        case (m)
            MODE_RING:  return 2'd1;
            MODE_LIST:  return 2'd3;
            MODE_ARRAY: return 2'd0;
            default:    return 2'd3;
        endcase
    endfunction

    // Meaning of descriptor word idx in the given layout
    function automatic dsc_role_e role_of(dsc_mode_e m, logic [1:0] idx);
        dsc_role_e r;
        r = ROLE_ADDR;
        case (m)
            MODE_RING:  r = (idx == 2'd0) ? ROLE_LINK : ROLE_ADDR;
            MODE_LIST:  r = dsc_role_e'(idx);
            MODE_ARRAY: r = ROLE_ADDR;
            default: begin
                case (idx)
                    2'd0:    r = ROLE_CFG;
                    2'd1:    r = ROLE_LINK;
                    2'd2:    r = ROLE_ADDR;
                    default: r = ROLE_LEN;
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsc_rd_port.sv
// Module: dsc_rd_port
// Turns a one-cycle issue strobe into a valid/ready read request and
// returns the response word as a one-cycle strobe. Holds exactly one read
// in flight. Assumes issue is only raised while port_idle is high.
module dsc_rd_port
    import dsc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    output logic          port_idle,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          word_valid,
    output logic [DW-1:0] word_data
);

    rdp_st_e       st_q;
    logic [AW-1:0] addr_q;

    // Request/response state and latched address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RP_IDLE;
            addr_q <= '0;
        end else begin
            case (st_q)
                RP_IDLE: begin
                    if (issue) begin
                        addr_q <= issue_addr;
                        st_q   <= RP_REQ;
                    end
                end
                RP_REQ: begin
                    if (mem_req_ready) begin
                        st_q <= RP_WAIT;
                    end
                end
                RP_WAIT: begin
                    if (mem_rsp_valid) begin
                        st_q <= RP_IDLE;
                    end
                end
                default: st_q <= RP_IDLE;
            endcase
        end
    end

    // Port outputs derived from state
    always_comb begin
        port_idle     = (st_q == RP_IDLE);
        mem_req_valid = (st_q == RP_REQ);
        mem_req_addr  = addr_q;
        word_valid    = (st_q == RP_WAIT) && mem_rsp_valid;
        word_data     = mem_rsp_data;
    end

endmodule

// File: rtl/dsc_walker.sv
// Module: dsc_walker
// Descriptor walking state machine: fetches the words of one descriptor,
// sorts them into fields by layout, presents the transfer and, on the
// engine's done pulse, follows the link, steps the array or stops.
// Assumes the read port is idle whenever the walker is in WK_ISSUE.
module dsc_walker
    import dsc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int CW = 8,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          start,
    input  logic [AW-1:0] first_ptr,
    input  logic [LW-1:0] shadow_len,
    input  logic [CW-1:0] shadow_cfg,
    input  logic [NW-1:0] arr_count,
    output logic          rd_issue,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_word_valid,
    input  logic [DW-1:0] rd_word_data,
    output logic          xfer_valid,
    output logic [AW-1:0] xfer_addr,
    output logic [LW-1:0] xfer_len,
    output logic [CW-1:0] xfer_cfg,
    input  logic          eng_done,
    output logic          irq_buf,
    output logic          irq_done,
    output logic          busy
);

    walk_st_e      st_q;
    dsc_mode_e     mode_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] link_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] len_q;
    logic [CW-1:0] cfg_q;
    logic [1:0]    widx_q;
    logic [NW-1:0] aidx_q;
    logic          irq_buf_q;
    logic          irq_done_q;
    logic          is_last;
    dsc_role_e     cur_role;

    // Decode of the current word's role and of end-of-chain
    always_comb begin
        cur_role = role_of(mode_q, widx_q);
        is_last  = cfg_q[CFG_LAST_BIT] ||
                   ((mode_q == MODE_ARRAY) && (aidx_q == arr_count - NW'(1)));
    end

    // Walk sequencing, field capture and interrupt pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= WK_IDLE;
            mode_q     <= MODE_RING;
            ptr_q      <= '0;
            link_q     <= '0;
            addr_q     <= '0;
            len_q      <= '0;
            cfg_q      <= '0;
            widx_q     <= '0;
            aidx_q     <= '0;
            irq_buf_q  <= 1'b0;
            irq_done_q <= 1'b0;
        end else begin
            irq_buf_q  <= 1'b0;
            irq_done_q <= 1'b0;
            case (st_q)
                WK_IDLE: begin
                    if (start) begin
                        mode_q <= dsc_mode_e'(cfg_mode);
                        ptr_q  <= first_ptr;
                        widx_q <= '0;
                        aidx_q <= '0;
                        len_q  <= shadow_len;
                        cfg_q  <= shadow_cfg;
                        st_q   <= WK_ISSUE;
                    end
                end
                WK_ISSUE: begin
                    st_q <= WK_WAIT;
                end
                WK_WAIT: begin
                    if (rd_word_valid) begin
                        case (cur_role)
                            ROLE_LINK: link_q <= rd_word_data[AW-1:0];
                            ROLE_ADDR: addr_q <= rd_word_data[AW-1:0];
                            ROLE_LEN:  len_q  <= rd_word_data[LW-1:0];
                            default:   cfg_q  <= rd_word_data[CW-1:0];
                        endcase
                        if (widx_q == last_word_idx(mode_q)) begin
                            widx_q <= '0;
                            st_q   <= WK_XFER;
                        end else begin
                            widx_q <= widx_q + 2'd1;
                            st_q   <= WK_ISSUE;
                        end
                    end
                end
                WK_XFER: begin
                    if (eng_done) begin
                        irq_buf_q <= cfg_q[CFG_END_BIT];
                        if (is_last) begin
                            irq_done_q <= 1'b1;
                            st_q       <= WK_IDLE;
                        end else begin
                            ptr_q  <= (mode_q == MODE_ARRAY) ? ptr_q + AW'(1) : link_q;
                            aidx_q <= aidx_q + NW'(1);
                            len_q  <= shadow_len;
                            cfg_q  <= shadow_cfg;
                            st_q   <= WK_ISSUE;
                        end
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    // Outputs toward the read port, the engine and the interrupt lines
    always_comb begin
        rd_issue   = (st_q == WK_ISSUE);
        rd_addr    = ptr_q + AW'(widx_q);
        xfer_valid = (st_q == WK_XFER);
        xfer_addr  = addr_q;
        xfer_len   = len_q;
        xfer_cfg   = cfg_q;
        irq_buf    = irq_buf_q;
        irq_done   = irq_done_q;
        busy       = (st_q != WK_IDLE);
    end

endmodule

// File: rtl/dsc_frac_irq.sv
// Module: dsc_frac_irq
// Counts engine beats during a transfer and pulses at the half point or
// the three quarter points of the buffer length. Counting restarts
// whenever no transfer is active. Assumes len and sel stay stable while
// active is high.
module dsc_frac_irq
    import dsc_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          beat,
    input  logic [LW-1:0] len,
    input  logic [1:0]    sel,
    output logic          irq_frac
);

    logic [LW-1:0] cnt_q;
    logic [1:0]    hit_q;
    logic          irq_q;
    logic [LW-1:0] step;
    logic [LW-1:0] mark;
    logic [1:0]    max_hits;
    logic [LW-1:0] cnt_nxt;

    // Step size, number of marks and the position of the next mark
    always_comb begin
        step     = (sel == FRAC_HALF) ? (len >> 1) : (len >> 2);
        max_hits = (sel == FRAC_HALF)    ? 2'd1 :
                   (sel == FRAC_QUARTER) ? 2'd3 : 2'd0;
        mark     = step;
        if (hit_q >= 2'd1) mark = mark + step;
        if (hit_q >= 2'd2) mark = mark + step;
        cnt_nxt  = cnt_q + LW'(1);
    end

    // Beat counter and registered mark pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!active) begin
                cnt_q <= '0;
                hit_q <= '0;
            end else if (beat) begin
                cnt_q <= cnt_nxt;
                if ((hit_q < max_hits) && (step != '0) && (cnt_nxt == mark)) begin
                    irq_q <= 1'b1;
                    hit_q <= hit_q + 2'd1;
                end
            end
        end
    end

    assign irq_frac = irq_q;

endmodule

// File: rtl/dsc_fetch_seq.sv
// Module: dsc_fetch_seq (top)
// DMA descriptor fetch sequencer: joins the read port, the descriptor
// walker and the fractional interrupt counter. Assumes the data engine
// pulses eng_beat once per moved word and eng_done once per transfer.
module dsc_fetch_seq
    import dsc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int CW = 8,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          start,
    input  logic [AW-1:0] first_ptr,
    input  logic [LW-1:0] shadow_len,
    input  logic [CW-1:0] shadow_cfg,
    input  logic [NW-1:0] arr_count,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          xfer_valid,
    output logic [AW-1:0] xfer_addr,
    output logic [LW-1:0] xfer_len,
    output logic [CW-1:0] xfer_cfg,
    input  logic          eng_beat,
    input  logic          eng_done,
    output logic          irq_frac,
    output logic          irq_buf,
    output logic          irq_done,
    output logic          busy
);

    logic          rd_issue;
    logic [AW-1:0] rd_addr;
    logic          rd_idle;
    logic          rd_word_valid;
    logic [DW-1:0] rd_word_data;

    dsc_rd_port #(.AW(AW), .DW(DW)) u_rd_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue         (rd_issue),
        .issue_addr    (rd_addr),
        .port_idle     (rd_idle),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .word_valid    (rd_word_valid),
        .word_data     (rd_word_data)
    );

    dsc_walker #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .NW(NW)) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode      (cfg_mode),
        .start         (start),
        .first_ptr     (first_ptr),
        .shadow_len    (shadow_len),
        .shadow_cfg    (shadow_cfg),
        .arr_count     (arr_count),
        .rd_issue      (rd_issue),
        .rd_addr       (rd_addr),
        .rd_word_valid (rd_word_valid),
        .rd_word_data  (rd_word_data),
        .xfer_valid    (xfer_valid),
        .xfer_addr     (xfer_addr),
        .xfer_len      (xfer_len),
        .xfer_cfg      (xfer_cfg),
        .eng_done      (eng_done),
        .irq_buf       (irq_buf),
        .irq_done      (irq_done),
        .busy          (busy)
    );

    dsc_frac_irq #(.LW(LW)) u_frac (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (xfer_valid),
        .beat     (eng_beat),
        .len      (xfer_len),
        .sel      (xfer_cfg[CFG_FRAC_LO +: 2]),
        .irq_frac (irq_frac)
    );

    // Issue is only legal toward an idle port
    always_comb begin
        if (rst_n && rd_issue) begin
            assert (rd_idle) else $error("read issued to a busy port");
        end
    end

endmodule

// File: rtl/dsc_fetch_seq_chk.sv
// Module: dsc_fetch_seq_chk
// Protocol checker bound to dsc_fetch_seq. Observes ports only and keeps
// its own record of whether a descriptor read is in flight.
module dsc_fetch_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int CW = 8,
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mode,
    input logic          start,
    input logic [AW-1:0] first_ptr,
    input logic [LW-1:0] shadow_len,
    input logic [CW-1:0] shadow_cfg,
    input logic [NW-1:0] arr_count,
    input logic          mem_req_valid,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_req_ready,
    input logic          mem_rsp_valid,
    input logic [DW-1:0] mem_rsp_data,
    input logic          xfer_valid,
    input logic [AW-1:0] xfer_addr,
    input logic [LW-1:0] xfer_len,
    input logic [CW-1:0] xfer_cfg,
    input logic          eng_beat,
    input logic          eng_done,
    input logic          irq_frac,
    input logic          irq_buf,
    input logic          irq_done,
    input logic          busy
);

    logic inflight_q;

    // Tracks an accepted read awaiting its response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            inflight_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            inflight_q <= 1'b0;
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q |-> !mem_req_valid); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

    AST_NO_FETCH_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !mem_req_valid); // R7

    AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !eng_done) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_cfg))); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> !busy); // R6

    AST_DONE_AFTER_ENG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(eng_done && xfer_valid)); // R6

    AST_BUF_AFTER_ENG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_buf |-> $past(eng_done && xfer_valid && xfer_cfg[1])); // R11

    AST_FRAC_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frac |-> $past(eng_beat && xfer_valid)); // R9

endmodule

bind dsc_fetch_seq dsc_fetch_seq_chk #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .NW(NW)) u_chk (.*);

// File: tb/test_dsc_fetch_seq.sv
// Testbench: table of per-layout walks, then directed tests.
module test_dsc_fetch_seq;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 16;
    localparam int CW = 8;
    localparam int NW = 8;

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  ptr;
        logic [7:0]  shcfg;
        logic [15:0] exp_addr;
        logic [15:0] exp_len;
        logic [7:0]  exp_cfg;
        logic [3:0]  exp_n;
        logic [3:0]  exp_nbuf;
        logic [15:0] exp_last_addr;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{2'd0, 8'd16, 8'h03, 16'h1000, 16'd8,  8'h03, 4'd1, 4'd1, 16'h1000},
        '{2'd1, 8'd32, 8'h00, 16'h3000, 16'd12, 8'h00, 4'd2, 4'd0, 16'h3100},
        '{2'd2, 8'd48, 8'h02, 16'h4000, 16'd8,  8'h02, 4'd3, 4'd3, 16'h4200},
        '{2'd3, 8'd64, 8'h00, 16'h5000, 16'd20, 8'h03, 4'd1, 4'd1, 16'h5000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic          start = 1'b0;
    logic [AW-1:0] first_ptr = '0;
    logic [LW-1:0] shadow_len = '0;
    logic [CW-1:0] shadow_cfg = '0;
    logic [NW-1:0] arr_count = '0;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b1;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          xfer_valid;
    logic [AW-1:0] xfer_addr;
    logic [LW-1:0] xfer_len;
    logic [CW-1:0] xfer_cfg;
    logic          eng_beat = 1'b0;
    logic          eng_done = 1'b0;
    logic          irq_frac;
    logic          irq_buf;
    logic          irq_done;
    logic          busy;

    logic [DW-1:0] mem [128];
    int            n_chk = 0;
    int            n_fail = 0;
    logic          stall_en = 1'b0;
    int            cyc = 0;
    logic          outst = 1'b0;
    int            mon_req_xfer = 0;
    int            mon_multi = 0;

    always #10 clk = ~clk;

    dsc_fetch_seq #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .NW(NW)) i_dsc_fetch_seq (.*);

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_req_addr[6:0]];
            outst         <= 1'b1;
        end else if (mem_rsp_valid) begin
            outst <= 1'b0;
        end
    end

    // Ready pattern and port monitors
    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            if (xfer_valid && mem_req_valid) mon_req_xfer = mon_req_xfer + 1;
            if (outst && mem_req_valid) mon_multi = mon_multi + 1;
            mem_req_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(input logic [1:0] m, input logic [7:0] p);
        cfg_mode  = m;
        first_ptr = AW'(p);
        start     = 1'b1;
        tick();
        start     = 1'b0;
    endtask

    task automatic wait_xfer(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (xfer_valid) begin
                ok = 1'b1;
                break;
            end
            tick();
        end
        if (!ok) check("R7 xfer timeout", 32'd0, 32'd1);
    endtask

    // Pulses done; samples the registered interrupts one edge later
    task automatic pulse_done(output logic b, output logic d, output logic f, output logic bz);
        eng_done = 1'b1;
        tick();
        eng_done = 1'b0;
        b = irq_buf; d = irq_done; f = irq_frac; bz = busy;
    endtask

    task automatic pulse_beat(output logic f);
        eng_beat = 1'b1;
        tick();
        eng_beat = 1'b0;
        f = irq_frac;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        // ring at 16/18
        mem[16] = 32'd18; mem[17] = 32'h1000;
        mem[18] = 32'd16; mem[19] = 32'h2000;
        // list at 32 -> 36
        mem[32] = 32'd36; mem[33] = 32'h3000; mem[34] = 32'd12; mem[35] = 32'h00;
        mem[36] = 32'd0;  mem[37] = 32'h3100; mem[38] = 32'd4;  mem[39] = 32'h01;
        // array at 48
        mem[48] = 32'h4000; mem[49] = 32'h4100; mem[50] = 32'h4200;
        // full at 64: cfg, link, addr, len
        mem[64] = 32'h03; mem[65] = 32'd0; mem[66] = 32'h5000; mem[67] = 32'd20;
        // quarter, half, collision descriptors (full layout)
        mem[80] = 32'h0B; mem[81] = 32'd0; mem[82] = 32'h6000; mem[83] = 32'd8;
        mem[88] = 32'h07; mem[89] = 32'd0; mem[90] = 32'h6100; mem[91] = 32'd6;
        mem[96] = 32'h0B; mem[97] = 32'd0; mem[98] = 32'h6200; mem[99] = 32'd8;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit   ok;
        logic b, d, f, bz;
        int   ntx, nbuf;
        logic [AW-1:0] last_a;

        repeat (3) tick();
        // R1: state held during and right after reset
        rst_n = 1'b1;
        tick();
        check("R1 busy", 32'(busy), 0);
        check("R1 xfer_valid", 32'(xfer_valid), 0);
        check("R1 mem_req_valid", 32'(mem_req_valid), 0);
        check("R1 irqs", {29'd0, irq_frac, irq_buf, irq_done}, 0);

        // Table walk: one entry per layout (R2 R3 R4 R5 R6 R11)
        shadow_len = 16'd8;
        arr_count  = 8'd3;
        stall_en   = 1'b1;
        foreach (VEC[k]) begin
            shadow_cfg = VEC[k].shcfg;
            do_start(VEC[k].mode, VEC[k].ptr);
            ntx = 0; nbuf = 0; last_a = '0;
            for (int t = 0; t < 6; t++) begin
                wait_xfer(ok);
                if (!ok) break;
                if (t == 0) begin
                    check($sformatf("R2-R5 addr mode%0d", VEC[k].mode), 32'(xfer_addr), 32'(VEC[k].exp_addr));
                    check($sformatf("R2-R5 len mode%0d", VEC[k].mode), 32'(xfer_len), 32'(VEC[k].exp_len));
                    check($sformatf("R2-R5 cfg mode%0d", VEC[k].mode), 32'(xfer_cfg), 32'(VEC[k].exp_cfg));
                end
                last_a = xfer_addr;
                ntx = ntx + 1;
                pulse_done(b, d, f, bz);
                if (b) nbuf = nbuf + 1;
                if (d) begin
                    check("R6 busy low with irq_done", 32'(bz), 0);
                    break;
                end
            end
            check($sformatf("R6 R4 transfer count mode%0d", VEC[k].mode), ntx, 32'(VEC[k].exp_n));
            check($sformatf("R11 end irq count mode%0d", VEC[k].mode), nbuf, 32'(VEC[k].exp_nbuf));
            check($sformatf("R3 R4 last addr mode%0d", VEC[k].mode), 32'(last_a), 32'(VEC[k].exp_last_addr));
            tick();
        end
        check("R8 one outstanding read", mon_multi, 0);

        // R2: ring loops back; shadow change takes effect at next fetch
        shadow_cfg = 8'h00;
        do_start(2'd0, 8'd16);
        wait_xfer(ok);
        check("R2 ring first", 32'(xfer_addr), 32'h1000);
        mon_req_xfer = 0;
        repeat (12) tick();
        check("R7 no fetch while presented", mon_req_xfer, 0);
        check("R7 still presented", 32'(xfer_valid), 1);
        pulse_done(b, d, f, bz);
        wait_xfer(ok);
        check("R2 ring second", 32'(xfer_addr), 32'h2000);
        pulse_done(b, d, f, bz);
        wait_xfer(ok);
        check("R2 ring wraps", 32'(xfer_addr), 32'h1000);
        shadow_cfg = 8'h01;
        pulse_done(b, d, f, bz);
        check("R6 not done before last", 32'(d), 0);
        wait_xfer(ok);
        check("R2 ring fourth", 32'(xfer_addr), 32'h2000);
        check("R2 shadow cfg sampled", 32'(xfer_cfg), 32'h01);
        pulse_done(b, d, f, bz);
        check("R6 irq_done on last", 32'(d), 1);
        check("R11 end irq off", 32'(b), 0);
        tick();

        // R10: quarter marks at beats 2,4,6 of length 8
        stall_en = 1'b0;
        do_start(2'd3, 8'd80);
        wait_xfer(ok);
        for (int i = 1; i <= 8; i++) begin
            pulse_beat(f);
            check($sformatf("R10 quarter beat %0d", i), 32'(f), 32'((i == 2) || (i == 4) || (i == 6)));
        end
        pulse_done(b, d, f, bz);
        check("R11 end irq on", 32'(b), 1);
        check("R6 done quarter", 32'(d), 1);
        tick();

        // R9: half mark at beat 3 of length 6
        do_start(2'd3, 8'd88);
        wait_xfer(ok);
        for (int i = 1; i <= 6; i++) begin
            pulse_beat(f);
            check($sformatf("R9 half beat %0d", i), 32'(f), 32'(i == 3));
        end
        pulse_done(b, d, f, bz);
        check("R11 end irq half", 32'(b), 1);
        tick();

        // R12: beat on a quarter mark together with done
        do_start(2'd3, 8'd96);
        wait_xfer(ok);
        pulse_beat(f);
        check("R12 first beat no mark", 32'(f), 0);
        eng_beat = 1'b1;
        pulse_done(b, d, f, bz);
        eng_beat = 1'b0;
        check("R12 frac with done", 32'(f), 1);
        check("R12 buf with frac", 32'(b), 1);
        check("R12 chain done", 32'(d), 1);
        tick();
        check("R8 one outstanding final", mon_multi, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule